// File: doc/BRIEF.md
# GEMM Loop Index Generator

This block sequences the buffer addressing of one matrix-multiply instruction. When it is started, it captures a micro-op window, the trip counts of two nested loops, and one outer and one inner step size for each of three buffers: accumulator, input and weight. It then walks the window inside the two loops. The micro-op index changes fastest, then the inner loop, then the outer loop. On every step it presents a micro-op address to an external micro-op store. It adds the running loop offsets to the three base indices that the store returns, and offers the result as one operation on a valid/ready output.

Each operation also carries a clear flag, captured at start. When the flag is set, the arithmetic unit overwrites the chosen accumulator entry instead of adding into it. The store answers in the same cycle as the address. The arithmetic unit that consumes the operations is not part of this block.

After the final operation has been handed off, the block pulses a completion strobe and is ready for the next start. An instruction with an empty window or a zero trip count produces no operations and completes at once.

Top module: `gemm_idx_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `op_valid` and `done` are 0.
- R2: Operations appear in the order outer loop i (slowest), inner loop j, then micro-op address k. Address k runs from `uop_begin` up to `uop_end - 1`. `uop_addr` always lies in that window while `op_valid` is 1.
- R3: `op_acc_idx` = `uop_acc_base` + i·`outer_acc_step` + j·`inner_acc_step`.
- R4: `op_inp_idx` and `op_wgt_idx` are formed as in R3, each from its own base and its own outer and inner steps.
- R5: Exactly `outer_count` × `inner_count` × (`uop_end` − `uop_begin`) operations are handed off per start. If `uop_end` ≤ `uop_begin`, or either count is 0, no operation is offered.
- R6: `done` is 1 for exactly one cycle. That cycle follows the clock edge of the final handoff, or the start edge of an empty instruction. `op_valid` is 0 while `done` is 1.
- R7: While `op_valid` is 1 and `op_ready` is 0, `op_valid` stays 1 and `uop_addr` stays unchanged.
- R8: `op_reset` equals the `clear_acc` value captured at start, for every operation of that instruction.
- R9: A `start` while operations are pending has no effect, and neither do changes on the configuration inputs. The running sequence continues with the captured values.
- R10: All indices are 11 bits wide and wrap modulo 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| uop_begin | input | 13 | First micro-op address of the window |
| uop_end | input | 13 | One past the last micro-op address |
| outer_count | input | 14 | Outer loop trip count |
| inner_count | input | 14 | Inner loop trip count |
| outer_acc_step | input | 11 | Accumulator step per outer iteration |
| outer_inp_step | input | 11 | Input step per outer iteration |
| outer_wgt_step | input | 11 | Weight step per outer iteration |
| inner_acc_step | input | 11 | Accumulator step per inner iteration |
| inner_inp_step | input | 11 | Input step per inner iteration |
| inner_wgt_step | input | 11 | Weight step per inner iteration |
| clear_acc | input | 1 | Operations overwrite instead of accumulate |
| uop_addr | output | 13 | Micro-op store read address |
| uop_acc_base | input | 11 | Accumulator base read from the store |
| uop_inp_base | input | 11 | Input base read from the store |
| uop_wgt_base | input | 11 | Weight base read from the store |
| op_valid | output | 1 | Operation offered |
| op_ready | input | 1 | Consumer accepts the operation |
| op_acc_idx | output | 11 | Accumulator index |
| op_inp_idx | output | 11 | Input index |
| op_wgt_idx | output | 11 | Weight index |
| op_reset | output | 1 | Clear flag of the operation |
| done | output | 1 | One-cycle completion strobe |

## Verification
The first operation is due one cycle after the start edge. Its indices follow the store's base values in that same cycle, because the store is read without a register in between. `done` is due one cycle after the edge of the final handoff, or one cycle after the start edge when the instruction is empty. It must be gone again one cycle later. The bench drives inputs and samples outputs on the falling edge. It decides the ready level and checks the offered operation in the same falling-edge slot. Each check therefore looks at exactly the operation that the next rising edge hands off. Stall cycles are checked for an unchanged address.

// File: rtl/gemm_idx_pkg.sv
package gemm_idx_pkg;

    localparam int IDX_W = 11;
    localparam int UOP_W = 13;
    localparam int CNT_W = 14;
    localparam int NBUF  = 3;

    localparam int BUF_ACC = 0;
    localparam int BUF_INP = 1;
    localparam int BUF_WGT = 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [UOP_W-1:0] uop_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        uop_t beg;
        uop_t fin;
        cnt_t outer_n;
        cnt_t inner_n;
    } loop_cfg_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

    function automatic logic cfg_is_empty(input loop_cfg_t c);
        return (c.fin <= c.beg) || (c.outer_n == '0) || (c.inner_n == '0);
    endfunction

endpackage

// File: rtl/gemm_loop_ctrl.sv
module gemm_loop_ctrl
    import gemm_idx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  loop_cfg_t cfg_in,
    input  loop_cfg_t cfg_q,
    input  logic      fire,
    output logic      running,
    output uop_t      uop_idx,
    output logic      load,
    output logic      adv_inner,
    output logic      adv_outer,
    output logic      done
);

    seq_state_e state;
    cnt_t       i_cnt;
    cnt_t       j_cnt;
    uop_t       k_cnt;
    logic       last_uop;
    logic       last_inner;
    logic       last_outer;
    logic       finish;

    assign running = (state == S_RUN);
    assign uop_idx = k_cnt;
    assign load    = start && (state == S_IDLE);

    always_comb begin
        last_uop   = (uop_t'(k_cnt + uop_t'(1)) == cfg_q.fin);
        last_inner = (cnt_t'(j_cnt + cnt_t'(1)) == cfg_q.inner_n);
        last_outer = (cnt_t'(i_cnt + cnt_t'(1)) == cfg_q.outer_n);
        adv_inner  = fire && last_uop && !last_inner;
        adv_outer  = fire && last_uop && last_inner && !last_outer;
        finish     = fire && last_uop && last_inner && last_outer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            i_cnt <= '0;
            j_cnt <= '0;
            k_cnt <= '0;
            done  <= 1'b0;
        end else begin
            done <= (load && cfg_is_empty(cfg_in)) || finish;
            case (state)
                S_IDLE: begin
                    if (load && !cfg_is_empty(cfg_in)) begin
                        state <= S_RUN;
                        i_cnt <= '0;
                        j_cnt <= '0;
                        k_cnt <= cfg_in.beg;
                    end
                end
                S_RUN: begin
                    if (fire) begin
                        if (!last_uop) begin
                            k_cnt <= uop_t'(k_cnt + uop_t'(1));
                        end else begin
                            k_cnt <= cfg_q.beg;
                            if (!last_inner) begin
                                j_cnt <= cnt_t'(j_cnt + cnt_t'(1));
                            end else begin
                                j_cnt <= '0;
                                if (!last_outer) begin
                                    i_cnt <= cnt_t'(i_cnt + cnt_t'(1));
                                end else begin
                                    state <= S_IDLE;
                                end
                            end
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gemm_offset_track.sv
module gemm_offset_track
    import gemm_idx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv_inner,
    input  logic adv_outer,
    input  idx_t outer_step,
    input  idx_t inner_step,
    output idx_t off
);

    idx_t outer_off;
    idx_t inner_off;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            outer_off <= '0;
            inner_off <= '0;
        end else if (adv_outer) begin
            outer_off <= idx_t'(outer_off + outer_step);
            inner_off <= '0;
        end else if (adv_inner) begin
            inner_off <= idx_t'(inner_off + inner_step);
        end
    end

    assign off = idx_t'(outer_off + inner_off);

endmodule

// File: rtl/gemm_idx_gen.sv
module gemm_idx_gen
    import gemm_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [UOP_W-1:0] uop_begin,
    input  logic [UOP_W-1:0] uop_end,
    input  logic [CNT_W-1:0] outer_count,
    input  logic [CNT_W-1:0] inner_count,
    input  logic [IDX_W-1:0] outer_acc_step,
    input  logic [IDX_W-1:0] outer_inp_step,
    input  logic [IDX_W-1:0] outer_wgt_step,
    input  logic [IDX_W-1:0] inner_acc_step,
    input  logic [IDX_W-1:0] inner_inp_step,
    input  logic [IDX_W-1:0] inner_wgt_step,
    input  logic             clear_acc,
    output logic [UOP_W-1:0] uop_addr,
    input  logic [IDX_W-1:0] uop_acc_base,
    input  logic [IDX_W-1:0] uop_inp_base,
    input  logic [IDX_W-1:0] uop_wgt_base,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [IDX_W-1:0] op_acc_idx,
    output logic [IDX_W-1:0] op_inp_idx,
    output logic [IDX_W-1:0] op_wgt_idx,
    output logic             op_reset,
    output logic             done
);

    loop_cfg_t cfg_in;
    loop_cfg_t cfg_q;
    logic      reset_q;
    logic      load;
    logic      adv_inner;
    logic      adv_outer;
    logic      running;
    logic      fire;
    uop_t      uop_idx;

    idx_t outer_step_in [NBUF];
    idx_t inner_step_in [NBUF];
    idx_t outer_step_q  [NBUF];
    idx_t inner_step_q  [NBUF];
    idx_t base_in       [NBUF];
    idx_t loop_off      [NBUF];
    idx_t idx_out       [NBUF];

    assign cfg_in = '{beg: uop_begin, fin: uop_end,
                      outer_n: outer_count, inner_n: inner_count};

    assign outer_step_in[BUF_ACC] = outer_acc_step;
    assign outer_step_in[BUF_INP] = outer_inp_step;
    assign outer_step_in[BUF_WGT] = outer_wgt_step;
    assign inner_step_in[BUF_ACC] = inner_acc_step;
    assign inner_step_in[BUF_INP] = inner_inp_step;
    assign inner_step_in[BUF_WGT] = inner_wgt_step;
    assign base_in[BUF_ACC]       = uop_acc_base;
    assign base_in[BUF_INP]       = uop_inp_base;
    assign base_in[BUF_WGT]       = uop_wgt_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            reset_q <= 1'b0;
        end else if (load) begin
            cfg_q   <= cfg_in;
            reset_q <= clear_acc;
        end
    end

    gemm_loop_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q),
        .fire      (fire),
        .running   (running),
        .uop_idx   (uop_idx),
        .load      (load),
        .adv_inner (adv_inner),
        .adv_outer (adv_outer),
        .done      (done)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                outer_step_q[b] <= '0;
                inner_step_q[b] <= '0;
            end else if (load) begin
                outer_step_q[b] <= outer_step_in[b];
                inner_step_q[b] <= inner_step_in[b];
            end
        end

        gemm_offset_track u_off (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .adv_inner  (adv_inner),
            .adv_outer  (adv_outer),
            .outer_step (outer_step_q[b]),
            .inner_step (inner_step_q[b]),
            .off        (loop_off[b])
        );

        assign idx_out[b] = idx_t'(base_in[b] + loop_off[b]);
    end

    assign fire       = running && op_ready;
    assign op_valid   = running;
    assign uop_addr   = uop_idx;
    assign op_reset   = reset_q;
    assign op_acc_idx = idx_out[BUF_ACC];
    assign op_inp_idx = idx_out[BUF_INP];
    assign op_wgt_idx = idx_out[BUF_WGT];

endmodule

// File: rtl/gemm_idx_gen_chk.sv
module gemm_idx_gen_chk
    import gemm_idx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      op_valid,
    input logic      op_ready,
    input logic      done,
    input logic      op_reset,
    input uop_t      uop_addr,
    input loop_cfg_t cfg_q
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!op_valid && !done));

    assert_addr_window_R2: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (uop_addr >= cfg_q.beg && uop_addr < cfg_q.fin));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && (uop_t'(uop_addr + uop_t'(1)) != cfg_q.fin))
        |=> (op_valid && uop_addr == uop_t'($past(uop_addr) + uop_t'(1))));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !op_valid);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> (op_valid && $stable(uop_addr)));

    assert_flag_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && $past(op_valid)) |-> $stable(op_reset));

endmodule

bind gemm_idx_gen gemm_idx_gen_chk u_chk (.*);

// File: tb/gemm_idx_gen_test.sv
module gemm_idx_gen_test;
    import gemm_idx_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    uop_t uop_begin = '0, uop_end = '0;
    cnt_t outer_count = '0, inner_count = '0;
    idx_t outer_acc_step = '0, outer_inp_step = '0, outer_wgt_step = '0;
    idx_t inner_acc_step = '0, inner_inp_step = '0, inner_wgt_step = '0;
    logic clear_acc = 1'b0;
    uop_t uop_addr;
    idx_t uop_acc_base, uop_inp_base, uop_wgt_base;
    logic op_valid;
    logic op_ready = 1'b0;
    idx_t op_acc_idx, op_inp_idx, op_wgt_idx;
    logic op_reset;
    logic done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog R5: actual cycles %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int acc_base_of(int k); return (k * 7) % 2048; endfunction
    function automatic int inp_base_of(int k); return (k * 3 + 5) % 2048; endfunction
    function automatic int wgt_base_of(int k); return (k * 11 + 1) % 2048; endfunction

    always_comb begin
        uop_acc_base = idx_t'(acc_base_of(int'(uop_addr)));
        uop_inp_base = idx_t'(inp_base_of(int'(uop_addr)));
        uop_wgt_base = idx_t'(wgt_base_of(int'(uop_addr)));
    end

    gemm_idx_gen uut (.*);

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    localparam int NV = 8;
    localparam int V_BEG [NV] = '{0, 8, 2, 0, 4, 0, 0, 5};
    localparam int V_END [NV] = '{8, 16, 5, 1, 4, 4, 4, 2};
    localparam int V_ON  [NV] = '{56, 3, 4, 5, 3, 0, 2, 2};
    localparam int V_IN  [NV] = '{2, 2, 3, 1, 3, 2, 0, 2};
    localparam int V_OA  [NV] = '{1, 0, 7, 2000, 1, 1, 1, 1};
    localparam int V_OI  [NV] = '{0, 5, 0, 3, 1, 1, 1, 1};
    localparam int V_OW  [NV] = '{0, 9, 3, 4, 1, 1, 1, 1};
    localparam int V_IA  [NV] = '{448, 100, 0, 1, 1, 1, 1, 1};
    localparam int V_II  [NV] = '{0, 1, 20, 1, 1, 1, 1, 1};
    localparam int V_IW  [NV] = '{0, 2, 1, 1, 1, 1, 1, 1};
    localparam int V_RF  [NV] = '{1, 0, 1, 0, 0, 1, 0, 1};
    localparam int V_CNT [NV] = '{896, 48, 36, 5, 0, 0, 0, 0};

    task automatic run_instr(input int beg, input int fin, input int on, input int inn,
                             input int oa, input int oi, input int ow,
                             input int ia, input int ii, input int iw,
                             input int rf, input int cnt_exp, input bit poke);
        int n = 0;
        @(negedge clk);
        uop_begin = uop_t'(beg); uop_end = uop_t'(fin);
        outer_count = cnt_t'(on); inner_count = cnt_t'(inn);
        outer_acc_step = idx_t'(oa); outer_inp_step = idx_t'(oi); outer_wgt_step = idx_t'(ow);
        inner_acc_step = idx_t'(ia); inner_inp_step = idx_t'(ii); inner_wgt_step = idx_t'(iw);
        clear_acc = rf[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (fin > beg) begin
            for (int i = 0; i < on; i++) begin
                for (int j = 0; j < inn; j++) begin
                    for (int k = beg; k < fin; k++) begin
                        bit got = 1'b0;
                        while (!got && !finished) begin
                            start = 1'b0;
                            op_ready = (cyc % 3) != 2;
                            if (op_valid && op_ready) begin
                                int ea = (acc_base_of(k) + i * oa + j * ia) % 2048;
                                int ei = (inp_base_of(k) + i * oi + j * ii) % 2048;
                                int ew = (wgt_base_of(k) + i * ow + j * iw) % 2048;
                                check(uop_addr == uop_t'(k), "R2 order uop_addr", int'(uop_addr), k);
                                check(op_acc_idx == idx_t'(ea), "R3/R10 acc index", int'(op_acc_idx), ea);
                                check(op_inp_idx == idx_t'(ei) && op_wgt_idx == idx_t'(ew),
                                      "R4 inp/wgt index", int'(op_inp_idx) * 2048 + int'(op_wgt_idx),
                                      ei * 2048 + ew);
                                check(op_reset == rf[0], "R8 op_reset", int'(op_reset), rf);
                                check(!done, "R6 done while busy", int'(done), 0);
                                got = 1'b1;
                                n++;
                                if (poke && n == 2) begin
                                    start = 1'b1;
                                    uop_begin = '0; uop_end = uop_t'(100);
                                    outer_acc_step = idx_t'(77); inner_acc_step = idx_t'(5);
                                    clear_acc = ~rf[0];
                                end
                            end else if (op_valid) begin
                                check(uop_addr == uop_t'(k), "R7 stall holds uop_addr",
                                      int'(uop_addr), k);
                            end else begin
                                check(1'b0, "R5 op_valid missing", 0, 1);
                            end
                            @(negedge clk);
                        end
                    end
                end
            end
        end
        start = 1'b0;
        op_ready = 1'b0;
        check(n == cnt_exp, "R5 operation count", n, cnt_exp);
        check(done == 1'b1, "R6 done after last handoff", int'(done), 1);
        check(!op_valid, "R5/R6 no valid when complete", int'(op_valid), 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        check(!op_valid, "R9 no restart from ignored start", int'(op_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!op_valid && !done, "R1 in reset", int'(op_valid) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!op_valid && !done, "R1 after reset", int'(op_valid) + int'(done), 0);

        for (int v = 0; v < NV; v++) begin
            run_instr(V_BEG[v], V_END[v], V_ON[v], V_IN[v], V_OA[v], V_OI[v], V_OW[v],
                      V_IA[v], V_II[v], V_IW[v], V_RF[v], V_CNT[v], 1'b0);
        end

        // R9: start and new settings mid-run are ignored
        run_instr(3, 7, 2, 3, 10, 20, 30, 100, 200, 300, 1, 24, 1'b1);

        // R10: wrap of every index past 2047
        run_instr(0, 2, 3, 2, 1500, 1900, 1024, 700, 1200, 1023, 0, 12, 1'b0);

        // R1: reset in the middle of a run
        @(negedge clk);
        uop_begin = '0; uop_end = uop_t'(4); outer_count = cnt_t'(3); inner_count = cnt_t'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(op_valid, "R2 running before reset", int'(op_valid), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!op_valid && !done, "R1 reset mid-run", int'(op_valid) + int'(done), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule